// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block is the digital half of a 16-bit successive-approximation analog-to-digital converter. Two active-low host strobes, a chip select and a read/convert line, are merged by a logical OR. The falling edge of that merged strobe starts a conversion. During a conversion the block puts the sampling switch into hold, clears its approximation register and tests one bit per trial, from the most significant bit down. It presents each trial word to the capacitive DAC and reads back a single comparator decision. A local clock times the conversion, and a parameter gives its length in clock cycles. At the end the result is copied into output latches as a two's-complement code, and busy returns high.

The host reads the result over a 16-bit data lane pair. The lanes are driven only while chip select is low and read/convert is high. A byte-select input exchanges the upper and lower lanes so that a byte-wide host can fetch both halves. A start that arrives during a running conversion has no effect. If the merged strobe is still low when a conversion ends, the next conversion begins at once, with no acquisition time in between.

Top module: `sar_ctrl_core`

## Requirements
- R1: A conversion starts on a falling edge of the merged strobe (cs_n OR rdconv), taken after a two-flop synchronizer. The merged strobe must have been sampled high for at least one clock before the edge. Either rdconv falling while cs_n is low, or cs_n falling while rdconv is low, starts a conversion.
- R2: hold is 1 in every cycle in which busy_n is 0. Both are inactive (hold 0, busy_n 1) in reset and while idle.
- R3: The approximation register is cleared at the start of a conversion, so the first trial word on dac_word is 16'h8000. Bits are then tried from bit 15 down to bit 0. A trial bit is kept when cmp_keep is 1, meaning the DAC value is less than or equal to the input, and is cleared otherwise.
- R4: busy_n stays low for exactly CONV_CYCLES consecutive clock cycles per conversion (default 115, about 2.3 µs at 50 MHz).
- R5: The output latches change only in the cycle in which busy_n rises. During a conversion the bus keeps showing the previous result.
- R6: A falling merged strobe during a conversion is ignored. The conversion length and the result are unchanged, and no extra conversion follows if the strobe is high again when busy_n rises.
- R7: If the merged strobe is still low when busy_n rises, busy_n stays high for exactly one cycle and a new conversion begins.
- R8: bus_oe is 1 only when cs_n is 0 and rdconv is 1. While bus_oe is 0, bus_q is all zeros.
- R9: With byte_sel 0, bus_q[15:8] carries result bits 15..8 and bus_q[7:0] carries bits 7..0. With byte_sel 1, the two 8-bit lanes are exchanged.
- R10: The result is the two's-complement code of the input. An offset-binary input value u produces u XOR 16'h8000, so the middle of the input range gives 16'h0000, the top gives 16'h7FFF and the bottom gives 16'h8000.
- R11: After reset the latched result is 16'h0000 and dac_word is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select, ORed with rdconv |
| rdconv | input | 1 | Read (high) / convert (low) strobe |
| byte_sel | input | 1 | 1 exchanges the upper and lower output lanes |
| cmp_keep | input | 1 | Comparator: 1 when the DAC value is at or below the input |
| dac_word | output | 16 | Trial word, offset binary, for the capacitive DAC |
| busy_n | output | 1 | Low while a conversion runs |
| hold | output | 1 | 1 puts the sampling switch into hold |
| bus_q | output | 16 | Result data lanes, zero while not enabled |
| bus_oe | output | 1 | Output enable for the three-state drivers |

## Verification
The bench checks both start orderings (rdconv falling with chip select low, and chip select falling with rdconv low). It injects a second start in the middle of a conversion and holds the merged strobe low across the end of a conversion. A core that restarted on the injected edge would lengthen busy beyond CONV_CYCLES. A core that missed the held strobe would leave busy high for longer than one cycle. Directed codes at mid-scale and at both full-scale ends, plus seeded random codes, check the MSB inversion and the trial order: a wrong keep or clear rule, or an off-by-one trial, shows up as a wrong code. Reading the bus in the middle of a conversion shows whether the latches leak partial register values. Byte-select and strobe combinations check the lane exchange and the all-zero bus while disabled.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int DATA_W      = 16;
    localparam int CONV_CYC_DF = 115;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } conv_state_e;

    typedef enum logic {
        PH_SET    = 1'b0,
        PH_DECIDE = 1'b1
    } trial_phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] approx;
        logic [DATA_W-1:0] probe;
    } trial_t;

    function automatic logic [DATA_W-1:0] offset_to_twos(input logic [DATA_W-1:0] u);
        logic [DATA_W-1:0] flip;
        flip = '0;
        flip[DATA_W-1] = 1'b1;
        return u ^ flip;
    endfunction

endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rdconv,
    output logic merged_low,
    output logic start_fall
);
    localparam int NSTROBE = 2;

    logic [NSTROBE-1:0] raw;
    logic [NSTROBE-1:0] synced;
    logic               merged_q;

    assign raw = {rdconv, cs_n};

    generate
        for (genvar s = 0; s < NSTROBE; s++) begin : g_sync
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], raw[s]};
                end
            end
            assign synced[s] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            merged_q <= 1'b1;
        end else begin
            merged_q <= |synced;
        end
    end

    assign merged_low = ~(|synced);
    assign start_fall = merged_q & ~(|synced);

endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine
    import sar_ctrl_pkg::*;
#(
    parameter int W           = DATA_W,
    parameter int CONV_CYCLES = CONV_CYC_DF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_fall,
    input  logic         merged_low,
    input  logic         cmp_keep,
    output logic [W-1:0] dac_word,
    output logic         busy_n,
    output logic         hold,
    output logic [W-1:0] result_word
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    conv_state_e  state;
    trial_phase_e phase;
    logic [CNT_W-1:0] cyc;
    logic [W-1:0] approx;
    logic [W-1:0] probe;
    logic         cmp_q;
    logic         rearm;
    logic         go;

    assign go = (state == ST_IDLE) && (start_fall || (rearm && merged_low));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            phase       <= PH_SET;
            cyc         <= '0;
            approx      <= '0;
            probe       <= '0;
            cmp_q       <= 1'b0;
            rearm       <= 1'b0;
            result_word <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    rearm <= 1'b0;
                    if (go) begin
                        state  <= ST_CONV;
                        phase  <= PH_SET;
                        cyc    <= '0;
                        approx <= '0;
                        probe  <= TOP_BIT;
                    end
                end
                default: begin
                    cyc <= cyc + 1'b1;
                    if (probe != '0) begin
                        if (phase == PH_SET) begin
                            cmp_q <= cmp_keep;
                            phase <= PH_DECIDE;
                        end else begin
                            if (cmp_q) begin
                                approx <= approx | probe;
                            end
                            probe <= probe >> 1;
                            phase <= PH_SET;
                        end
                    end
                    if (cyc == LAST) begin
                        result_word <= offset_to_twos(approx);
                        state       <= ST_IDLE;
                        rearm       <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign dac_word = approx | probe;
    assign busy_n   = (state == ST_IDLE);
    assign hold     = (state == ST_CONV);

endmodule

// File: rtl/sar_bus_lanes.sv
module sar_bus_lanes #(
    parameter int W = 16
) (
    input  logic         cs_n,
    input  logic         rdconv,
    input  logic         byte_sel,
    input  logic [W-1:0] result_word,
    output logic [W-1:0] bus_q,
    output logic         bus_oe
);
    localparam int HALF = W / 2;

    logic [W-1:0] lanes;

    generate
        for (genvar i = 0; i < HALF; i++) begin : g_lane
            assign lanes[i]        = byte_sel ? result_word[i + HALF] : result_word[i];
            assign lanes[i + HALF] = byte_sel ? result_word[i]        : result_word[i + HALF];
        end
    endgenerate

    assign bus_oe = ~cs_n & rdconv;
    assign bus_q  = bus_oe ? lanes : '0;

endmodule

// File: rtl/sar_ctrl_core.sv
module sar_ctrl_core
    import sar_ctrl_pkg::*;
#(
    parameter int W           = DATA_W,
    parameter int CONV_CYCLES = CONV_CYC_DF,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         rdconv,
    input  logic         byte_sel,
    input  logic         cmp_keep,
    output logic [W-1:0] dac_word,
    output logic         busy_n,
    output logic         hold,
    output logic [W-1:0] bus_q,
    output logic         bus_oe
);
    logic         merged_low;
    logic         start_fall;
    logic [W-1:0] result_word;

    sar_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rdconv     (rdconv),
        .merged_low (merged_low),
        .start_fall (start_fall)
    );

    sar_conv_engine #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_fall  (start_fall),
        .merged_low  (merged_low),
        .cmp_keep    (cmp_keep),
        .dac_word    (dac_word),
        .busy_n      (busy_n),
        .hold        (hold),
        .result_word (result_word)
    );

    sar_bus_lanes #(.W(W)) u_lanes (
        .cs_n        (cs_n),
        .rdconv      (rdconv),
        .byte_sel    (byte_sel),
        .result_word (result_word),
        .bus_q       (bus_q),
        .bus_oe      (bus_oe)
    );

endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
    parameter int W           = 16,
    parameter int CONV_CYCLES = 115
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         rdconv,
    input logic [W-1:0] dac_word,
    input logic         busy_n,
    input logic         hold,
    input logic [W-1:0] bus_q,
    input logic         bus_oe,
    input logic [W-1:0] result_word
);
    localparam int RUN_W = $clog2(CONV_CYCLES + 2) + 1;
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || busy_n) begin
            low_run <= '0;
        end else if (low_run != '1) begin
            low_run <= low_run + 1'b1;
        end
    end

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (low_run == RUN_W'(CONV_CYCLES)));

    assert_hold_in_conv_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_n |-> hold);

    assert_msb_first_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> (dac_word == TOP_BIT));

    assert_latch_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_word) |-> $rose(busy_n));

    assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !rdconv) |-> (!bus_oe && bus_q == '0));

endmodule

bind sar_ctrl_core sar_ctrl_checker #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .rdconv      (rdconv),
    .dac_word    (dac_word),
    .busy_n      (busy_n),
    .hold        (hold),
    .bus_q       (bus_q),
    .bus_oe      (bus_oe),
    .result_word (result_word)
);

// File: tb/tb_sar_ctrl_core.sv
`timescale 1ns/1ps
module tb_sar_ctrl_core;
    localparam int W    = 16;
    localparam int CONV = 115;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic rdconv = 1'b1;
    logic byte_sel = 1'b0;
    logic cmp_keep;
    logic [W-1:0] dac_word;
    logic busy_n;
    logic hold;
    logic [W-1:0] bus_q;
    logic bus_oe;

    logic [W-1:0] vin_u = 16'h8000;   // analog input as offset binary
    logic [W-1:0] prev_res = 16'h0000;
    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    // comparator model of the analog front end
    assign cmp_keep = (dac_word <= vin_u);

    sar_ctrl_core #(.W(W), .CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rdconv(rdconv), .byte_sel(byte_sel),
        .cmp_keep(cmp_keep), .dac_word(dac_word), .busy_n(busy_n), .hold(hold),
        .bus_q(bus_q), .bus_oe(bus_oe)
    );

    function automatic logic [W-1:0] exp_code(input logic [W-1:0] u);
        return u ^ 16'h8000;
    endfunction

    function automatic logic [W-1:0] exp_swap(input logic [W-1:0] c);
        return {c[7:0], c[15:8]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // waits for busy_n low; returns 1 if seen
    task automatic wait_busy_fall(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!busy_n) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic read_result(input logic [W-1:0] exp, input string tag);
        byte_sel = 1'b0;
        #1;
        check(bus_oe == 1'b1, "R8 bus enabled for read", bus_oe, 1);
        check(bus_q == exp, tag, bus_q, exp);
        byte_sel = 1'b1;
        #1;
        check(bus_q == exp_swap(exp), "R9 lanes exchanged", bus_q, exp_swap(exp));
        byte_sel = 1'b0;
        #1;
    endtask

    // rdconv-driven conversion with cs_n low; optional mid-conversion restart attempt
    task automatic conv_rc(input logic [W-1:0] u, input bit inject, input string tag);
        bit seen;
        int len;
        @(negedge clk);
        vin_u = u;
        cs_n = 1'b0;
        rdconv = 1'b0;
        wait_busy_fall(seen);
        check(seen, "R1 start by rdconv fall", seen, 1);
        check(dac_word == 16'h8000, "R3 first trial word", dac_word, 16'h8000);
        check(hold == 1'b1, "R2 hold during conversion", hold, 1);
        rdconv = 1'b1;
        len = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy_n) break;
            len++;
            if (len == 60) begin
                #1;
                check(bus_q == prev_res, "R5 previous result during conversion", bus_q, prev_res);
            end
            if (inject && len == 70) rdconv = 1'b0;
            if (inject && len == 76) rdconv = 1'b1;
        end
        check(len == CONV, inject ? "R6 length unchanged by restart attempt" : "R4 busy length", len, CONV);
        read_result(exp_code(u), tag);
        prev_res = exp_code(u);
        if (inject) begin
            bit stay;
            stay = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!busy_n) stay = 1'b0;
            end
            check(stay, "R6 no extra conversion after ignored start", stay, 1);
        end
    endtask

    // chip-select-driven conversion with rdconv low
    task automatic conv_cs(input logic [W-1:0] u, input string tag);
        bit seen;
        int len;
        @(negedge clk);
        vin_u = u;
        cs_n = 1'b1;
        rdconv = 1'b1;
        repeat (4) @(negedge clk);
        rdconv = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_busy_fall(seen);
        check(seen, "R1 start by cs_n fall", seen, 1);
        cs_n = 1'b1;
        rdconv = 1'b1;
        len = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy_n) break;
            len++;
        end
        check(len == CONV, "R4 busy length cs start", len, CONV);
        #1;
        check(bus_oe == 1'b0 && bus_q == 16'h0, "R8 bus quiet with cs_n high", bus_q, 0);
        cs_n = 1'b0;
        read_result(exp_code(u), tag);
        prev_res = exp_code(u);
    endtask

    initial begin
        bit seen;
        int len;
        int hi;
        void'($urandom(32'd1606));
        repeat (5) @(negedge clk);
        check(busy_n == 1'b1 && hold == 1'b0, "R2 idle during reset", {busy_n, hold}, 2'b10);
        check(dac_word == 16'h0, "R11 dac word in reset", dac_word, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(busy_n == 1'b1, "R1 no start without falling strobe", busy_n, 1);
        cs_n = 1'b0;
        #1;
        check(bus_q == 16'h0000, "R11 result zero after reset", bus_q, 0);
        cs_n = 1'b1;
        #1;
        check(bus_oe == 1'b0 && bus_q == 16'h0, "R8 bus off, cs_n high", bus_q, 0);

        // directed codes
        conv_rc(16'h8000, 1'b0, "R10 mid-scale gives 0000");
        conv_rc(16'hFFFF, 1'b0, "R10 top gives 7FFF");
        conv_rc(16'h0000, 1'b0, "R10 bottom gives 8000");
        conv_rc(16'h7FFF, 1'b0, "R10 just below mid gives FFFF");
        conv_rc(16'h8001, 1'b0, "R3 LSB trial kept");
        conv_cs(16'h1234, "R1 cs-started result");
        conv_rc(16'hA5C3, 1'b1, "R6 result unaffected by restart attempt");

        // immediate retrigger with merged strobe held low
        @(negedge clk);
        vin_u = 16'h4C21;
        cs_n = 1'b0;
        rdconv = 1'b0;
        #1;
        check(bus_oe == 1'b0, "R8 bus off while rdconv low", bus_oe, 0);
        wait_busy_fall(seen);
        len = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy_n) break;
            len++;
        end
        check(len == CONV, "R4 length before retrigger", len, CONV);
        hi = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!busy_n) break;
            hi++;
        end
        check(hi == 1, "R7 busy high one cycle then restart", hi, 1);
        rdconv = 1'b1;
        len = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy_n) break;
            len++;
        end
        check(len == CONV, "R7 second conversion length", len, CONV);
        read_result(exp_code(16'h4C21), "R7 retriggered result");
        prev_res = exp_code(16'h4C21);

        // seeded random codes
        for (int k = 0; k < 24; k++) begin
            logic [W-1:0] r;
            r = W'($urandom);
            if (k % 3 == 2) conv_cs(r, "R10 random code cs");
            else            conv_rc(r, 1'b0, "R10 random code");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule